// File: doc/BRIEF.md
# Serial Exception Coprocessor Registers

This block is the exception-recording part of a small 32-bit processor whose datapath moves one bit per cycle. The pipeline raises request lines for an external interrupt, arithmetic overflow, coprocessor-unusable, reserved-instruction and address-error conditions, and supplies the program counter of the faulting instruction. When the block accepts a request, it saves that program counter, a cause code and, for address errors, the offending data address. It clears the interrupt-enable bit, and on the following cycle it raises a one-cycle redirect strobe beside a constant handler address.

Software reaches the saved state as it reaches data memory, one bit per cycle. A serial port selects one of the registers and shifts it toward bit 0. In write mode a new bit enters at the top. In read mode the outgoing bit wraps around, so a full-word read leaves the register unchanged. Each exception class can be removed with a build parameter. Removing address errors also removes the bad-address register.

Top module: `exc_cop_serial`

## Requirements
- R1: After reset, all held registers read back as zero and `take_exc` is low.
- R2: The register selector codes are 0 = saved PC, 1 = cause, 2 = status and 3 = bad address. With `acc_en` and `acc_wr` high, each cycle shifts the selected register down by one bit and places `acc_wbit` in the top bit. After XLEN cycles, the first bit supplied is in bit 0.
- R3: With `acc_en` high and `acc_wr` low, `acc_rbit` shows bit 0 of the selected register before each shift, and the outgoing bit re-enters at the top. A full-word read therefore returns the value least significant bit first and leaves the register unchanged.
- R4: `take_exc` is high for exactly the cycle after the clock edge at which an enabled request was accepted. `vec_pc` always equals the VEC_ADDR parameter.
- R5: When a request is accepted, the saved-PC register loads `fault_pc`.
- R6: When a request is accepted, the cause register loads the 5-bit code in bits 6:2, and all other bits are zero. The codes are 0 for interrupt, 4 for address error on a load or fetch (`ade_store` = 0), 5 for address error on a store, 10 for reserved instruction, 11 for coprocessor unusable and 12 for overflow.
- R7: When several requests are present together, exactly one is accepted. The order of precedence is address error, then reserved instruction, then coprocessor unusable, then overflow, then interrupt.
- R8: An interrupt request is accepted only while status bit 0 (interrupt enable) is 1.
- R9: Accepting a request clears status bit 0 and leaves the other status bits unchanged.
- R10: An accepted address error loads `bad_addr` into the bad-address register. Other accepted exceptions leave that register unchanged.
- R11: A request of a class removed by its parameter has no effect: `take_exc` stays low and no register changes. With address errors removed, selector 3 always reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | External interrupt request |
| ovf_req | input | 1 | Arithmetic overflow request |
| cpu_req | input | 1 | Coprocessor-unusable request |
| ri_req | input | 1 | Reserved-instruction request |
| ade_req | input | 1 | Address-error request |
| ade_store | input | 1 | Address error came from a store (1) or from a load or fetch (0) |
| fault_pc | input | XLEN | PC of the faulting instruction |
| bad_addr | input | XLEN | Offending data address |
| acc_en | input | 1 | Serial access shift enable |
| acc_wr | input | 1 | Serial access is a write |
| acc_sel | input | 2 | Register selector |
| acc_wbit | input | 1 | Serial write data bit |
| take_exc | output | 1 | One-cycle redirect strobe |
| vec_pc | output | XLEN | Fixed handler address |
| acc_rbit | output | 1 | Serial read data bit (bit 0 of the selected register) |

## Verification
The bench builds two instances with XLEN = 8. The first has every class enabled. The second has overflow and address errors removed and receives the same stimulus. An 8-bit word makes it practical to write and then read back every one of the 256 values in every register selector. The bench applies all 32 combinations of the five request lines, with the interrupt enable both set and clear. This covers every precedence case, every cause code, both address-error kinds and the masked interrupt. The second instance shows, in the same runs, that removed classes and the absent bad-address register have no effect.

// File: rtl/exc_cop_pkg.sv
// Shared constants for the serial exception coprocessor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package exc_cop_pkg;

    // Register selector codes seen on the serial access port.
    localparam logic [1:0] SEL_EPC    = 2'd0;
    localparam logic [1:0] SEL_CAUSE  = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;
    localparam logic [1:0] SEL_BADVA  = 2'd3;
    localparam int         NUM_SEL    = 4;

    // Cause code field width and position inside the cause register.
    localparam int CODE_W   = 5;
    localparam int CODE_LSB = 2;

    // Exception codes that software decodes.
    localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_ADEL = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ADES = 5'd5;
    localparam logic [CODE_W-1:0] CODE_RI   = 5'd10;
    localparam logic [CODE_W-1:0] CODE_CPU  = 5'd11;
    localparam logic [CODE_W-1:0] CODE_OVF  = 5'd12;

endpackage

// File: rtl/exc_prio.sv
// Request qualifier and fixed-priority selector.
// Removes classes disabled at build time, masks the interrupt with the
// enable bit, and picks one winner: address error > reserved instr >
// coprocessor unusable > overflow > interrupt. Purely combinational.
module exc_prio
    import exc_cop_pkg::*;
#(
    parameter bit EN_OVF = 1'b1,
    parameter bit EN_CPU = 1'b1,
    parameter bit EN_RI  = 1'b1,
    parameter bit EN_ADE = 1'b1
) (
    input  logic              irq,
    input  logic              ie,
    input  logic              ovf,
    input  logic              cpu,
    input  logic              ri,
    input  logic              ade,
    input  logic              ade_store,
    output logic              take,
    output logic              ade_hit,
    output logic [CODE_W-1:0] code
);

    logic ovf_g, cpu_g, ri_g, ade_g;

    // Build-time removal of each optional class.
    generate
        if (EN_OVF) begin : g_ovf
            assign ovf_g = ovf;
        end else begin : g_no_ovf
            assign ovf_g = 1'b0;
        end
        if (EN_CPU) begin : g_cpu
            assign cpu_g = cpu;
        end else begin : g_no_cpu
            assign cpu_g = 1'b0;
        end
        if (EN_RI) begin : g_ri
            assign ri_g = ri;
        end else begin : g_no_ri
            assign ri_g = 1'b0;
        end
        if (EN_ADE) begin : g_ade
            assign ade_g = ade;
        end else begin : g_no_ade
            assign ade_g = 1'b0;
        end
    endgenerate

    // Fixed-priority choice of the winning class and its code.
    always_comb begin
        take    = 1'b1;
        ade_hit = 1'b0;
        code    = CODE_INT;
        if (ade_g) begin
            ade_hit = 1'b1;
            code    = ade_store ? CODE_ADES : CODE_ADEL;
        end else if (ri_g) begin
            code = CODE_RI;
        end else if (cpu_g) begin
            code = CODE_CPU;
        end else if (ovf_g) begin
            code = CODE_OVF;
        end else if (irq && ie) begin
            code = CODE_INT;
        end else begin
            take = 1'b0;
        end
    end

endmodule

// File: rtl/ser_reg.sv
// One serially accessed register with a parallel load for exception capture.
// Shifts toward bit 0 when enabled; the top bit takes the write bit or,
// in read mode, the outgoing bit 0 (rotate). A parallel load wins over a shift.
module ser_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         wr,
    input  logic         wbit,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);

    // Register update: reset, capture, or one-bit shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {(wr ? wbit : q[0]), q[W-1:1]};
        end
    end

endmodule

// File: rtl/exc_cop_serial.sv
// Serial exception coprocessor: saved PC, cause, status and optional
// bad-address registers, each a shift register reached through a one-bit
// access port. Assumes request lines are asserted for one cycle by the
// pipeline and that software does not access while an exception is raised.
module exc_cop_serial
    import exc_cop_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_ADDR = XLEN'(32'h0000_0080),
    parameter bit              EN_OVF   = 1'b1,
    parameter bit              EN_CPU   = 1'b1,
    parameter bit              EN_RI    = 1'b1,
    parameter bit              EN_ADE   = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq,
    input  logic            ovf_req,
    input  logic            cpu_req,
    input  logic            ri_req,
    input  logic            ade_req,
    input  logic            ade_store,
    input  logic [XLEN-1:0] fault_pc,
    input  logic [XLEN-1:0] bad_addr,
    input  logic            acc_en,
    input  logic            acc_wr,
    input  logic [1:0]      acc_sel,
    input  logic            acc_wbit,
    output logic            take_exc,
    output logic [XLEN-1:0] vec_pc,
    output logic            acc_rbit
);

    localparam int NREG = EN_ADE ? NUM_SEL : NUM_SEL - 1;

    logic [NUM_SEL-1:0][XLEN-1:0] regs_q;
    logic [NUM_SEL-1:0][XLEN-1:0] ld_val;
    logic [NUM_SEL-1:0]           ld;
    logic                         take_now;
    logic                         ade_hit;
    logic [CODE_W-1:0]            code;
    logic                         ie;

    assign ie = regs_q[SEL_STATUS][0];

    exc_prio #(
        .EN_OVF (EN_OVF),
        .EN_CPU (EN_CPU),
        .EN_RI  (EN_RI),
        .EN_ADE (EN_ADE)
    ) u_prio (
        .irq       (irq),
        .ie        (ie),
        .ovf       (ovf_req),
        .cpu       (cpu_req),
        .ri        (ri_req),
        .ade       (ade_req),
        .ade_store (ade_store),
        .take      (take_now),
        .ade_hit   (ade_hit),
        .code      (code)
    );

    // Capture values and load strobes for each register.
    always_comb begin
        ld_val[SEL_EPC]    = fault_pc;
        ld_val[SEL_CAUSE]  = XLEN'(code) << CODE_LSB;
        ld_val[SEL_STATUS] = {regs_q[SEL_STATUS][XLEN-1:1], 1'b0};
        ld_val[SEL_BADVA]  = bad_addr;
        ld[SEL_EPC]        = take_now;
        ld[SEL_CAUSE]      = take_now;
        ld[SEL_STATUS]     = take_now;
        ld[SEL_BADVA]      = take_now && ade_hit;
    end

    // One shift register per present selector; absent ones read zero.
    generate
        for (genvar k = 0; k < NUM_SEL; k++) begin : g_reg
            if (k < NREG) begin : g_on
                ser_reg #(.W(XLEN)) u_reg (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .shift    (acc_en && (acc_sel == 2'(k))),
                    .wr       (acc_wr),
                    .wbit     (acc_wbit),
                    .load     (ld[k]),
                    .load_val (ld_val[k]),
                    .q        (regs_q[k])
                );
            end else begin : g_off
                assign regs_q[k] = '0;
            end
        end
    endgenerate

    // Redirect strobe, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_exc <= 1'b0;
        end else begin
            take_exc <= take_now;
        end
    end

    assign vec_pc   = VEC_ADDR;
    assign acc_rbit = regs_q[acc_sel][0];

endmodule

// File: rtl/exc_cop_checker.sv
// Temporal checks for exc_cop_serial, attached by bind below.
// Observes request inputs, the strobe and the captured registers.
module exc_cop_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic         ovf_req,
    input logic         cpu_req,
    input logic         ri_req,
    input logic         ade_req,
    input logic [W-1:0] fault_pc,
    input logic         take_exc,
    input logic         ie,
    input logic [W-1:0] epc,
    input logic [W-1:0] cause
);

    // R4: no request at all never produces a strobe.
    a_r4_no_spurious_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !ovf_req && !cpu_req && !ri_req && !ade_req) |=> !take_exc);

    // R5: the saved PC is the faulting PC presented at acceptance.
    a_r5_epc_captured: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (epc == $past(fault_pc)));

    // R6: the cause register holds only the code field.
    a_r6_cause_frame: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> ((cause[1:0] == 2'b00) && ((cause >> 7) == '0)));

    // R8: a lone interrupt while disabled is not accepted.
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ie && !ovf_req && !cpu_req && !ri_req && !ade_req) |=> !take_exc);

    // R9: the enable bit is clear whenever the strobe is raised.
    a_r9_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> !ie);

endmodule

bind exc_cop_serial exc_cop_checker #(.W(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .ovf_req  (ovf_req),
    .cpu_req  (cpu_req),
    .ri_req   (ri_req),
    .ade_req  (ade_req),
    .fault_pc (fault_pc),
    .take_exc (take_exc),
    .ie       (regs_q[2][0]),
    .epc      (regs_q[0]),
    .cause    (regs_q[1])
);

// File: tb/tb_exc_cop_serial.sv
module tb_exc_cop_serial;

    localparam int         W   = 8;
    localparam logic [W-1:0] VEC = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq = 0, ovf_req = 0, cpu_req = 0, ri_req = 0, ade_req = 0, ade_store = 0;
    logic [W-1:0] fault_pc = '0, bad_addr = '0;
    logic acc_en = 0, acc_wr = 0, acc_wbit = 0;
    logic [1:0] acc_sel = '0;
    logic take_a, take_b, rbit_a, rbit_b;
    logic [W-1:0] vec_a, vec_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_cop_serial #(.XLEN(W), .VEC_ADDR(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .ovf_req(ovf_req), .cpu_req(cpu_req),
        .ri_req(ri_req), .ade_req(ade_req), .ade_store(ade_store), .fault_pc(fault_pc),
        .bad_addr(bad_addr), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
        .acc_wbit(acc_wbit), .take_exc(take_a), .vec_pc(vec_a), .acc_rbit(rbit_a)
    );

    exc_cop_serial #(.XLEN(W), .VEC_ADDR(VEC), .EN_OVF(1'b0), .EN_ADE(1'b0)) dut_nx (
        .clk(clk), .rst_n(rst_n), .irq(irq), .ovf_req(ovf_req), .cpu_req(cpu_req),
        .ri_req(ri_req), .ade_req(ade_req), .ade_store(ade_store), .fault_pc(fault_pc),
        .bad_addr(bad_addr), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
        .acc_wbit(acc_wbit), .take_exc(take_b), .vec_pc(vec_b), .acc_rbit(rbit_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serial write, bit 0 first, to both instances.
    task automatic wr_word(input logic [1:0] sel, input logic [W-1:0] v);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            acc_en = 1; acc_wr = 1; acc_sel = sel; acc_wbit = v[i];
        end
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_wbit = 0;
    endtask

    // Serial read (rotating) from both instances.
    task automatic rd_word(input logic [1:0] sel, output logic [W-1:0] a, output logic [W-1:0] b);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            acc_en = 1; acc_wr = 0; acc_sel = sel;
            #1;
            a[i] = rbit_a;
            b[i] = rbit_b;
        end
        @(negedge clk);
        acc_en = 0;
    endtask

    // Winning code for given requests and build options; -1 when none accepted.
    function automatic int pick(input logic [4:0] m, input logic ie, input logic st,
                                input bit en_ovf, input bit en_ade);
        if (m[4] && en_ade) return st ? 5 : 4;
        if (m[3]) return 10;
        if (m[2]) return 11;
        if (m[1] && en_ovf) return 12;
        if (m[0] && ie) return 0;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] ra, rb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state.
        chk("R1 take", {31'b0, take_a}, 0);
        chk("R4 vec_pc", {24'b0, vec_a}, {24'b0, VEC});
        for (int s = 0; s < 4; s++) begin
            rd_word(2'(s), ra, rb);
            chk("R1 reg", {24'b0, ra}, 0);
            chk("R1 reg nx", {24'b0, rb}, 0);
        end

        // R2/R3: every value through every selector.
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
                wr_word(2'(s), W'(v));
                rd_word(2'(s), ra, rb);
                chk("R2 write", {24'b0, ra}, v);
                chk((s == 3) ? "R11 absent reg" : "R2 write nx", {24'b0, rb}, (s == 3) ? 0 : v);
                rd_word(2'(s), ra, rb);
                chk("R3 reread", {24'b0, ra}, v);
            end
        end

        // R4..R11: all request combinations, interrupt enable on and off.
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 32; m++) begin
                logic [W-1:0] f, st_pre;
                logic st;
                int ca, cb;
                f      = W'(m * 7 + 3 + ie * 64);
                st_pre = 8'hA4 | W'(ie);
                st     = logic'((m >> 1) & 1) ^ logic'(ie);
                wr_word(2'd0, 8'h11);
                wr_word(2'd1, 8'h00);
                wr_word(2'd2, st_pre);
                wr_word(2'd3, 8'h22);
                ca = pick(5'(m), logic'(ie), st, 1'b1, 1'b1);
                cb = pick(5'(m), logic'(ie), st, 1'b0, 1'b0);

                @(negedge clk);
                {ade_req, ri_req, cpu_req, ovf_req, irq} = 5'(m);
                ade_store = st; fault_pc = f; bad_addr = ~f;
                @(negedge clk);
                {ade_req, ri_req, cpu_req, ovf_req, irq} = '0;
                chk((m == 1 && ie == 0) ? "R8 masked" : "R4 take", {31'b0, take_a}, (ca >= 0) ? 1 : 0);
                chk("R11 take nx", {31'b0, take_b}, (cb >= 0) ? 1 : 0);
                @(negedge clk);
                chk("R4 pulse", {31'b0, take_a}, 0);

                rd_word(2'd0, ra, rb);
                chk("R5 epc", {24'b0, ra}, (ca >= 0) ? {24'b0, f} : 32'h11);
                chk("R11 epc nx", {24'b0, rb}, (cb >= 0) ? {24'b0, f} : 32'h11);
                rd_word(2'd1, ra, rb);
                chk(($countones(m) > 1) ? "R7 prio" : "R6 code", {24'b0, ra}, (ca >= 0) ? (ca << 2) : 0);
                chk("R11 code nx", {24'b0, rb}, (cb >= 0) ? (cb << 2) : 0);
                rd_word(2'd2, ra, rb);
                chk("R9 status", {24'b0, ra}, (ca >= 0) ? {24'b0, st_pre & 8'hFE} : {24'b0, st_pre});
                chk("R11 status nx", {24'b0, rb}, (cb >= 0) ? {24'b0, st_pre & 8'hFE} : {24'b0, st_pre});
                rd_word(2'd3, ra, rb);
                chk("R10 badaddr", {24'b0, ra}, (ca == 4 || ca == 5) ? {24'b0, ~f} : 32'h22);
                chk("R11 badaddr nx", {24'b0, rb}, 0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule